// File: doc/BRIEF.md
# Accumulator Processor with Four Operand Addressing Modes

This block is a small multi-cycle processor built around one accumulator. It fetches 16-bit instructions from a single synchronous byte-wide memory, decodes them and finds the operand in one of four ways. The operand field can be the value itself (immediate). It can be the address of the value (direct). It can be the address of a full-width pointer to the value (indirect). Or it can be a base that the index register is added to (indexed). The instruction set covers loading, storing, adding and subtracting with the accumulator, plus loading, stepping and comparing the index register, and a branch that tests the result of that comparison. This is enough to walk an array in a counted loop.

Memory is outside the block. The processor drives an address, write data and a write strobe, and takes back read data one cycle after it presents an address. Every instruction runs as a fixed walk through a small state machine: two fetch cycles, a decode cycle, then zero, one or two operand reads, then an execute cycle. A halt instruction parks the processor until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low and after it rises, `halted` is 0 and `mem_we` is 0. Execution starts by fetching address 0. The accumulator, the index register and the equal flag all start at zero, so a branch-if-not-equal as the first instruction is taken.
- R2: An instruction is two bytes fetched from consecutive addresses, first byte at the program counter. Bits [15:12] are the opcode, [11:10] the mode (00 immediate, 01 direct, 10 indirect, 11 indexed), [9:8] are ignored and [7:0] are the operand field. Any byte address, even or odd, may start an instruction.
- R3: In immediate mode the operand field is the value. An instruction that takes an operand this way needs 4 cycles and reads no operand from memory.
- R4: In direct mode the value is read from the address given by the operand field. The instruction takes 5 cycles.
- R5: In indirect mode the byte at the operand-field address is read as a full 8-bit pointer, and the value is then read from that pointer. The instruction takes 6 cycles.
- R6: In indexed mode the value is read from address (operand field + index register) mod 256. The instruction takes 5 cycles.
- R7: Opcode 0001 loads the accumulator, 0011 adds the operand to it and 0100 subtracts the operand from it. Results wrap modulo 256.
- R8: Opcode 0010 writes the accumulator to the effective address and leaves the accumulator unchanged. It takes 4 cycles in direct or indexed mode and 5 cycles in indirect mode, where the pointer gives the target. In immediate mode it writes nothing and takes 4 cycles.
- R9: Opcode 0101 loads the index register from the operand and 0110 increments it modulo 256. Opcode 0111 sets the equal flag when the index register equals the operand and clears it otherwise.
- R10: Opcode 1000 jumps to the operand field, whatever the mode, when the equal flag is 0. Otherwise execution falls through to the next instruction. It takes 4 cycles.
- R11: Opcode 1111 raises `halted` 3 cycles after its fetch begins. From then until reset, `halted` stays high, `mem_addr` holds the halt instruction's own address and no write is made.
- R12: Opcodes 0000 and 1001 to 1110 change no state except to advance to the next instruction. They take 4 cycles and make no write.
- R13: An instruction makes at most one write, and writes never occur in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Byte address presented to memory this cycle |
| mem_wdata | output | 8 | Data to write when `mem_we` is high |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 8 | Byte read at the address presented in the previous cycle |
| halted | output | 1 | High once a halt instruction has been decoded, until reset |

## Verification
The memory port follows a fixed request/response timing with no back-pressure, so the block contains no valid/ready handshake. Two functions can fall in the same cycle. The decode cycle advances the program counter and also starts the operand read, and in indexed mode that read uses the index register written by the previous instruction's execute cycle. A taken branch then overrides the program counter that decode has already advanced. An array-summing loop provokes both effects: an indexed add follows each compare and branch, and the loop re-enters through a taken branch. Each run is judged by the stored total for several array lengths, together with branch tests whose result is stored at a fixed address.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_DECODE,
    ST_PTR_READ,
    ST_DATA_READ,
    ST_EXECUTE,
    ST_HALT
  } cpu_state_e;

  localparam logic [3:0] OP_LDA = 4'b0001;
  localparam logic [3:0] OP_STA = 4'b0010;
  localparam logic [3:0] OP_ADD = 4'b0011;
  localparam logic [3:0] OP_SUB = 4'b0100;
  localparam logic [3:0] OP_LDX = 4'b0101;
  localparam logic [3:0] OP_INX = 4'b0110;
  localparam logic [3:0] OP_CMX = 4'b0111;
  localparam logic [3:0] OP_BNE = 4'b1000;
  localparam logic [3:0] OP_HLT = 4'b1111;

  localparam logic [1:0] MODE_IMM = 2'b00;
  localparam logic [1:0] MODE_DIR = 2'b01;
  localparam logic [1:0] MODE_IND = 2'b10;
  localparam logic [1:0] MODE_IDX = 2'b11;

  // Opcodes whose operand is resolved through the addressing mode
  function automatic logic takes_operand(input logic [3:0] op);
    return (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_LDX) || (op == OP_CMX);
  endfunction

endpackage

// File: rtl/acc_cpu_agu.sv
module acc_cpu_agu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] field_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] ix_i,
  output logic [W-1:0] ea_o
);
  // Indexed mode offsets the base by the index register; others use it as is
  always_comb begin
    if (mode_i == MODE_IDX) ea_o = field_i + ix_i;
    else                    ea_o = field_i;
  end
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_i,
  input  logic [3:0]   opcode_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] ix_o,
  output logic         eq_o
);
  logic [W-1:0] acc_q, ix_q;
  logic         eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ix_q  <= '0;
      eq_q  <= 1'b0;
    end else if (exec_i) begin
      case (opcode_i)
        OP_LDA:  acc_q <= opnd_i;
        OP_ADD:  acc_q <= acc_q + opnd_i;
        OP_SUB:  acc_q <= acc_q - opnd_i;
        OP_LDX:  ix_q  <= opnd_i;
        OP_INX:  ix_q  <= ix_q + W'(1);
        OP_CMX:  eq_q  <= (ix_q == opnd_i);
        default: ;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign ix_o  = ix_q;
  assign eq_o  = eq_q;
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mem_rdata,
  input  logic [W-1:0] ea_i,
  input  logic [W-1:0] acc_i,
  input  logic         eq_i,
  output logic [1:0]   mode_o,
  output logic [3:0]   opcode_o,
  output logic [W-1:0] opnd_o,
  output cpu_state_e   state_o,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we
);
  localparam int OPC_LSB  = W - 4;
  localparam int MODE_LSB = W - 6;
  localparam logic [W-1:0] STEP = W'(2);

  cpu_state_e   state_q, state_d;
  logic [W-1:0] pc_q, pc_d;
  logic [W-1:0] ir_q, ir_d;
  logic [W-1:0] opnd_q, opnd_d;
  logic [W-1:0] ea_q, ea_d;

  logic [3:0] opc;
  logic [1:0] mode;
  assign opc  = ir_q[OPC_LSB +: 4];
  assign mode = ir_q[MODE_LSB +: 2];

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ir_d      = ir_q;
    opnd_d    = opnd_q;
    ea_d      = ea_q;
    mem_addr  = pc_q;
    mem_wdata = acc_i;
    mem_we    = 1'b0;
    unique case (state_q)
      ST_FETCH_HI: state_d = ST_FETCH_LO;
      ST_FETCH_LO: begin
        mem_addr = pc_q + W'(1);
        ir_d     = mem_rdata;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        if (opc == OP_HLT) begin
          state_d = ST_HALT;
        end else begin
          pc_d    = pc_q + STEP;
          opnd_d  = mem_rdata;
          ea_d    = ea_i;
          state_d = ST_EXECUTE;
          if (opc == OP_STA) begin
            if (mode == MODE_IND) begin
              mem_addr = mem_rdata;
              state_d  = ST_PTR_READ;
            end
          end else if (takes_operand(opc)) begin
            if (mode == MODE_IND) begin
              mem_addr = mem_rdata;
              state_d  = ST_PTR_READ;
            end else if (mode != MODE_IMM) begin
              mem_addr = ea_i;
              state_d  = ST_DATA_READ;
            end
          end
        end
      end
      ST_PTR_READ: begin
        ea_d = mem_rdata;
        if (opc == OP_STA) begin
          state_d = ST_EXECUTE;
        end else begin
          mem_addr = mem_rdata;
          state_d  = ST_DATA_READ;
        end
      end
      ST_DATA_READ: begin
        opnd_d  = mem_rdata;
        state_d = ST_EXECUTE;
      end
      ST_EXECUTE: begin
        if (opc == OP_STA && mode != MODE_IMM) begin
          mem_addr = ea_q;
          mem_we   = 1'b1;
        end
        if (opc == OP_BNE && !eq_i) pc_d = opnd_q;
        state_d = ST_FETCH_HI;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH_HI;
      pc_q    <= '0;
      ir_q    <= '0;
      opnd_q  <= '0;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      opnd_q  <= opnd_d;
      ea_q    <= ea_d;
    end
  end

  assign mode_o   = mode;
  assign opcode_o = opc;
  assign opnd_o   = opnd_q;
  assign state_o  = state_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata,
  output logic         halted
);
  cpu_state_e   state_q;
  logic [1:0]   mode;
  logic [3:0]   opcode;
  logic [W-1:0] opnd, ea, acc, ix;
  logic         eq;

  acc_cpu_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .ea_i(ea),
    .acc_i(acc), .eq_i(eq), .mode_o(mode), .opcode_o(opcode),
    .opnd_o(opnd), .state_o(state_q), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  acc_cpu_agu #(.W(W)) agu_i (
    .field_i(mem_rdata), .mode_i(mode), .ix_i(ix), .ea_o(ea)
  );

  acc_cpu_dp #(.W(W)) dp_i (
    .clk(clk), .rst_n(rst_n), .exec_i(state_q == ST_EXECUTE),
    .opcode_i(opcode), .opnd_i(opnd), .acc_o(acc), .ix_o(ix), .eq_o(eq)
  );

  assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         halted,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input cpu_state_e   state
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R11
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R11
  AST_HALT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(mem_addr)); // R11
  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R13
  AST_WRITE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state) == ST_DECODE || $past(state) == ST_PTR_READ)); // R8
  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH_LO) |-> (mem_addr == W'($past(mem_addr) + 1))); // R2
endmodule

bind acc_cpu acc_cpu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_we(mem_we),
  .mem_addr(mem_addr), .state(state_q)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic [7:0] mem [256];
  int         wr_count = 0;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_count      <= wr_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
  endtask

  task automatic put(input int a, input logic [3:0] op, input logic [1:0] md,
                     input int f);
    mem[a & 255]       = {op, md, 2'b00};
    mem[(a + 1) & 255] = 8'(f);
  endtask

  // Reset, release, count edges until halted
  task automatic run(output int cyc);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n    = 1'b1;
    wr_count = 0;
    cyc      = 0;
    while (!halted && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk("watchdog run timeout", 0, 1);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc, expv, f, k, a, b, sum;
    logic [7:0] snap [256];

    // R1: reset state seen at the ports
    fill();
    @(negedge clk);
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 we in reset", int'(mem_we), 0);
    chk("R1 fetch address", int'(mem_addr), 0);

    // R3 R4 R5 R6: operand modes swept with index offsets
    for (int md = 0; md < 4; md++) begin
      for (int j = 0; j < 16; j++) begin
        fill();
        f = 8'h40 + j * 11;
        k = (j * 13) & 255;
        put(0, 4'h5, 2'd0, k);
        put(2, 4'h1, 2'(md), f);
        put(4, 4'h2, 2'd1, 8'hF0);
        put(6, 4'hF, 2'd0, 0);
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        case (md)
          0: expv = f;
          1: expv = snap[f];
          2: expv = snap[snap[f]];
          default: expv = snap[(f + k) & 255];
        endcase
        run(cyc);
        case (md)
          0: chk("R3 immediate value", mem[8'hF0], expv);
          1: chk("R4 direct value", mem[8'hF0], expv);
          2: chk("R5 indirect value", mem[8'hF0], expv);
          default: chk("R6 indexed value", mem[8'hF0], expv);
        endcase
        chk(md == 0 ? "R3 cycles" : md == 2 ? "R5 cycles" : "R4 R6 cycles",
            cyc, 4 + 4 + 3 + (md == 0 ? 4 : md == 2 ? 6 : 5));
      end
    end

    // R7: add/subtract sweep with wrap, immediate and direct operands
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          fill();
          a = i * 17;
          b = (j * 23 + 5) & 255;
          mem[8'h50] = 8'(b);
          put(0, 4'h1, 2'd0, a);
          put(2, op == 0 ? 4'h3 : 4'h4, j[0] ? 2'd1 : 2'd0, j[0] ? 8'h50 : b);
          put(4, 4'h2, 2'd1, 8'hF0);
          put(6, 4'hF, 2'd0, 0);
          run(cyc);
          expv = (op == 0) ? (a + b) & 255 : (a - b + 256) & 255;
          chk(op == 0 ? "R7 add wrap" : "R7 sub wrap", mem[8'hF0], expv);
        end
      end
    end

    // R8: indirect store, accumulator kept, two writes
    fill();
    mem[8'h30] = 8'hC8; mem[8'hC8] = 8'h00;
    put(0, 4'h1, 2'd0, 8'h3C);
    put(2, 4'h2, 2'd2, 8'h30);
    put(4, 4'h2, 2'd1, 8'hF2);
    put(6, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R8 indirect store target", mem[8'hC8], 8'h3C);
    chk("R8 acc unchanged by store", mem[8'hF2], 8'h3C);
    chk("R8 write count", wr_count, 2);
    chk("R8 store cycles", cyc, 4 + 5 + 4 + 3);

    // R8: indexed store
    fill();
    put(0, 4'h5, 2'd0, 5);
    put(2, 4'h1, 2'd0, 8'h77);
    put(4, 4'h2, 2'd3, 8'hA0);
    put(6, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R8 indexed store", mem[8'hA5], 8'h77);

    // R8: immediate-mode store writes nothing
    fill();
    mem[8'hF1] = 8'hAA;
    put(0, 4'h1, 2'd0, 8'h55);
    put(2, 4'h2, 2'd0, 8'hF1);
    put(4, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R8 immediate store no write", mem[8'hF1], 8'hAA);
    chk("R8 immediate store write count", wr_count, 0);
    chk("R8 immediate store cycles", cyc, 4 + 4 + 3);

    // R1 R10: flag clear after reset, first branch taken
    fill();
    put(0, 4'h8, 2'd0, 8'h10);
    put(2, 4'h1, 2'd0, 8'h11); put(4, 4'h2, 2'd1, 8'hF0); put(6, 4'hF, 2'd0, 0);
    put(8'h10, 4'h1, 2'd0, 8'h5A); put(8'h12, 4'h2, 2'd1, 8'hF0); put(8'h14, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R1 R10 branch after reset", mem[8'hF0], 8'h5A);

    // R9 R10: increment wraps, compare equal, branch falls through
    fill();
    put(0, 4'h5, 2'd0, 255); put(2, 4'h6, 2'd0, 0); put(4, 4'h7, 2'd0, 0);
    put(6, 4'h8, 2'd0, 8'h20);
    put(8, 4'h1, 2'd0, 1); put(10, 4'h2, 2'd1, 8'hF0); put(12, 4'hF, 2'd0, 0);
    put(8'h20, 4'h1, 2'd0, 2); put(8'h22, 4'h2, 2'd1, 8'hF0); put(8'h24, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R9 inc wrap and compare equal", mem[8'hF0], 1);

    // R9 R10: compare against memory operand, unequal, branch taken
    fill();
    mem[8'h60] = 4;
    put(0, 4'h5, 2'd0, 3); put(2, 4'h7, 2'd1, 8'h60);
    put(4, 4'h8, 2'd3, 8'h20);
    put(6, 4'h1, 2'd0, 1); put(8, 4'h2, 2'd1, 8'hF0); put(10, 4'hF, 2'd0, 0);
    put(8'h20, 4'h1, 2'd0, 2); put(8'h22, 4'h2, 2'd1, 8'hF0); put(8'h24, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R9 R10 compare unequal branch taken", mem[8'hF0], 2);

    // R2: instruction at odd address
    fill();
    put(0, 4'h8, 2'd0, 8'h31);
    put(8'h31, 4'h1, 2'd0, 8'h66); put(8'h33, 4'h2, 2'd1, 8'hF0); put(8'h35, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R2 odd address fetch", mem[8'hF0], 8'h66);

    // R6 R9 R10: array loop, lengths 1..8
    for (int n = 1; n <= 8; n++) begin
      fill();
      put(0, 4'h1, 2'd0, 0); put(2, 4'h5, 2'd0, 0);
      put(4, 4'h3, 2'd3, 8'h80); put(6, 4'h6, 2'd0, 0);
      put(8, 4'h7, 2'd0, n); put(10, 4'h8, 2'd0, 4);
      put(12, 4'h2, 2'd1, 8'hF0); put(14, 4'hF, 2'd0, 0);
      sum = 0;
      for (int i = 0; i < n; i++) sum += mem[8'h80 + i];
      run(cyc);
      chk("R6 R9 R10 loop sum", mem[8'hF0], sum & 255);
    end

    // R12: undefined opcodes leave accumulator alone
    fill();
    put(0, 4'h1, 2'd0, 8'h21); put(2, 4'h9, 2'd0, 8'h99);
    put(4, 4'hE, 2'd1, 8'h40); put(6, 4'h0, 2'd2, 8'h41);
    put(8, 4'h2, 2'd1, 8'hF0); put(10, 4'hF, 2'd0, 0);
    run(cyc);
    chk("R12 undefined opcode no effect", mem[8'hF0], 8'h21);
    chk("R12 undefined opcode cycles", cyc, 4 * 5 + 3);

    // R11: halt holds address, no writes, stays high
    k = wr_count;
    repeat (20) @(negedge clk);
    chk("R11 halted stays", int'(halted), 1);
    chk("R11 address frozen at halt", int'(mem_addr), 10);
    chk("R11 no writes while halted", wr_count, k);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 reset clears halted", int'(halted), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule